// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between an 8-bit host bus and the counting logic of a three-channel interval timer. A 2-bit address selects one of four byte locations. Locations 0, 1 and 2 are the count registers of the channels, and location 3 is the control register, which can only be written. Control writes do one of three things: they reprogram a channel, they freeze a channel's running count, or they issue a read-back command that captures count and status for several channels at once.

Counts are 16 bits wide but the bus is 8 bits wide, so every channel has an access mode that sets how bytes map onto its count. Each channel keeps its own write and read byte pointers, a byte holding register, a captured count and a captured status byte. The block passes each channel's mode, access mode and decimal flag to the counting logic. On every count write that completes a value, it sends a one-cycle load strobe with the assembled 16-bit value. It reads back each channel's live count and output pin. A read returns data in the same cycle as the read strobe, and any pointer or latch update takes effect at the clock edge that ends that cycle.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel has access mode 3 (low then high byte), mode 3 and decimal flag 0. No load strobe is active, no latch is pending, and the first live read of a channel returns its low byte.
- R2: A control write with bits 7:6 equal to a channel number 0..2 and bits 5:4 nonzero copies bits 5:4 to that channel's access mode, bits 3:1 to its mode and bit 0 to its decimal flag. It also returns both of that channel's byte pointers to the low byte.
- R3: A count write depends on the access mode. Mode 1 loads {0x00, byte}. Mode 2 loads {byte, 0x00}. Mode 3 holds the first byte without loading, and the second byte loads {second, first}.
- R4: Each load raises exactly one channel's load strobe for exactly one cycle, in the cycle after the write, with the assembled value on that channel's load-value field.
- R5: A control write with bits 5:4 equal to 0 captures the selected channel's live count. A further capture request while a captured count is still unread is ignored.
- R6: A control write with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 clear captures the count and bit 4 clear captures the status. The status is {output, 0, access[1:0], mode[2:0], decimal} from bit 7 down to bit 0. A status capture is ignored while a captured status is still unread.
- R7: A channel read returns a pending status first and clears it. Otherwise it returns the captured count and then releases it: in mode 1 the low byte, in mode 2 the high byte, and in mode 3 the low byte and then the high byte. Otherwise it returns the live count.
- R8: Live reads return the low byte in mode 1 and the high byte in mode 2 on every read. In mode 3 they alternate low, high, starting from the low byte.
- R9: A read of address 3 returns 0xFF and changes no pointer or latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe, one byte per cycle |
| host_addr | input | 2 | 0..2 channel count register, 3 control register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the read cycle |
| tc_acc | output | 2*NCH | Access mode per channel |
| tc_mode | output | 3*NCH | Counting mode per channel |
| tc_bcd | output | NCH | Decimal flag per channel |
| tc_load | output | NCH | One-cycle load strobe per channel |
| tc_load_val | output | 16*NCH | Count value that goes with the load strobe |
| tc_count | input | 16*NCH | Live count of each channel |
| tc_out | input | NCH | Output pin of each channel |

## Verification
The assertions check on every cycle that at most one load strobe is high, and that a load strobe follows a count write. They also check that channel configuration changes only after a control write, that no channel ever holds access mode 0, and that reads of address 3 return 0xFF. Byte ordering, the capture and ignore rules for the count and status latches, and the priority of status over captured count over live count all depend on a sequence of operations. Only the bench's sweeps over channels and access modes can show these.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] lat_cnt,
  output logic [NCH-1:0] lat_sts,
  output chcfg_t        cfg_in
);
  logic [1:0] sel;
  logic       ctrl_wr;
  logic       readback;

  assign sel      = wdata[7:6];
  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign readback = (sel == 2'd3);
  assign cfg_in   = '{acc: acc_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};

  always_comb begin
    prog    = '0;
    lat_cnt = '0;
    lat_sts = '0;
    if (ctrl_wr) begin
      if (readback) begin
        // select bits 1..NCH map to channels 0..NCH-1
        for (int i = 0; i < NCH; i++) begin
          if (wdata[i+1]) begin
            lat_cnt[i] = !wdata[5];
            lat_sts[i] = !wdata[4];
          end
        end
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (sel == 2'(i)) begin
            if (wdata[5:4] == 2'd0) lat_cnt[i] = 1'b1;
            else                    prog[i]    = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  chcfg_t        cfg_in,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wbyte,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_pin,
  output chcfg_t        cfg,
  output logic [DW-1:0] rbyte,
  output logic          load,
  output logic [CW-1:0] load_val
);
  chcfg_t        cfg_q,      cfg_n;
  logic          wr_hi_q,    wr_hi_n;
  logic [DW-1:0] hold_q,     hold_n;
  logic          rd_hi_q,    rd_hi_n;
  acc_e          cl_st_q,    cl_st_n;
  logic [CW-1:0] cl_val_q,   cl_val_n;
  logic          sl_pend_q,  sl_pend_n;
  logic [DW-1:0] sl_val_q,   sl_val_n;
  logic          load_q,     load_n;
  logic [CW-1:0] ldval_q,    ldval_n;

  logic cfg_en, cl_en, sl_en, hold_en, ldval_en;

  logic [DW-1:0] live_lo, live_hi;
  assign live_lo = live_cnt[DW-1:0];
  assign live_hi = live_cnt[CW-1:DW];

  // next-state logic
  always_comb begin
    cfg_n     = cfg_q;
    wr_hi_n   = wr_hi_q;
    hold_n    = hold_q;
    rd_hi_n   = rd_hi_q;
    cl_st_n   = cl_st_q;
    cl_val_n  = cl_val_q;
    sl_pend_n = sl_pend_q;
    sl_val_n  = sl_val_q;
    load_n    = 1'b0;
    ldval_n   = ldval_q;
    cfg_en    = 1'b0;
    cl_en     = 1'b0;
    sl_en     = 1'b0;
    hold_en   = 1'b0;
    ldval_en  = 1'b0;

    if (prog) begin
      cfg_en  = 1'b1;
      cfg_n   = cfg_in;
      wr_hi_n = 1'b0;
      rd_hi_n = 1'b0;
    end

    if (lat_cnt && (cl_st_q == ACC_NONE)) begin
      cl_en    = 1'b1;
      cl_val_n = live_cnt;
      cl_st_n  = cfg_q.acc;
    end

    if (lat_sts && !sl_pend_q) begin
      sl_en     = 1'b1;
      sl_pend_n = 1'b1;
      sl_val_n  = {out_pin, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
    end

    if (wr) begin
      unique case (cfg_q.acc)
        ACC_LO: begin
          load_n   = 1'b1;
          ldval_en = 1'b1;
          ldval_n  = {{DW{1'b0}}, wbyte};
        end
        ACC_HI: begin
          load_n   = 1'b1;
          ldval_en = 1'b1;
          ldval_n  = {wbyte, {DW{1'b0}}};
        end
        default: begin
          if (!wr_hi_q) begin
            hold_en = 1'b1;
            hold_n  = wbyte;
            wr_hi_n = 1'b1;
          end else begin
            load_n   = 1'b1;
            ldval_en = 1'b1;
            ldval_n  = {wbyte, hold_q};
            wr_hi_n  = 1'b0;
          end
        end
      endcase
    end

    if (rd) begin
      if (sl_pend_q) begin
        sl_pend_n = 1'b0;
      end else if (cl_st_q != ACC_NONE) begin
        cl_st_n = (cl_st_q == ACC_WORD) ? ACC_HI : ACC_NONE;
      end else if (cfg_q.acc == ACC_WORD) begin
        rd_hi_n = !rd_hi_q;
      end
    end
  end

  // read data selection: status, then captured count, then live count
  always_comb begin
    if (sl_pend_q) begin
      rbyte = sl_val_q;
    end else if (cl_st_q == ACC_HI) begin
      rbyte = cl_val_q[CW-1:DW];
    end else if (cl_st_q != ACC_NONE) begin
      rbyte = cl_val_q[DW-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rbyte = live_hi;
        ACC_WORD: rbyte = rd_hi_q ? live_hi : live_lo;
        default:  rbyte = live_lo;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{acc: ACC_WORD, mode: 3'd3, bcd: 1'b0};
      wr_hi_q   <= 1'b0;
      hold_q    <= '0;
      rd_hi_q   <= 1'b0;
      cl_st_q   <= ACC_NONE;
      cl_val_q  <= '0;
      sl_pend_q <= 1'b0;
      sl_val_q  <= '0;
      load_q    <= 1'b0;
      ldval_q   <= '0;
    end else begin
      if (cfg_en)   cfg_q    <= cfg_n;
      if (hold_en)  hold_q   <= hold_n;
      if (cl_en)    cl_val_q <= cl_val_n;
      if (sl_en)    sl_val_q <= sl_val_n;
      if (ldval_en) ldval_q  <= ldval_n;
      wr_hi_q   <= wr_hi_n;
      rd_hi_q   <= rd_hi_n;
      cl_st_q   <= cl_st_n;
      sl_pend_q <= sl_pend_n;
      load_q    <= load_n;
    end
  end

  assign cfg      = cfg_q;
  assign load     = load_q;
  assign load_val = ldval_q;
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic [2*NCH-1:0]  tc_acc,
  output logic [3*NCH-1:0]  tc_mode,
  output logic [NCH-1:0]    tc_bcd,
  output logic [NCH-1:0]    tc_load,
  output logic [CW*NCH-1:0] tc_load_val,
  input  logic [CW*NCH-1:0] tc_count,
  input  logic [NCH-1:0]    tc_out
);
  logic          rst_n_s;
  logic [NCH-1:0] prog, lat_cnt, lat_sts;
  chcfg_t        cfg_in;
  chcfg_t        cfg   [NCH];
  logic [DW-1:0] rbyte [NCH];

  tmr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  tmr_ctl_decode #(.NCH(NCH)) u_dec (
    .wr_en   (host_wr),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .prog    (prog),
    .lat_cnt (lat_cnt),
    .lat_sts (lat_sts),
    .cfg_in  (cfg_in)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_hit;
    assign ch_hit = (host_addr == 2'(i));

    tmr_chan_regs u_ch (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .prog     (prog[i]),
      .cfg_in   (cfg_in),
      .lat_cnt  (lat_cnt[i]),
      .lat_sts  (lat_sts[i]),
      .wr       (host_wr && ch_hit),
      .rd       (host_rd && ch_hit),
      .wbyte    (host_wdata),
      .live_cnt (tc_count[CW*i +: CW]),
      .out_pin  (tc_out[i]),
      .cfg      (cfg[i]),
      .rbyte    (rbyte[i]),
      .load     (tc_load[i]),
      .load_val (tc_load_val[CW*i +: CW])
    );

    assign tc_acc[2*i +: 2]  = cfg[i].acc;
    assign tc_mode[3*i +: 3] = cfg[i].mode;
    assign tc_bcd[i]         = cfg[i].bcd;
  end

  always_comb begin
    host_rdata = {DW{1'b1}};
    for (int i = 0; i < NCH; i++) begin
      if (host_addr == 2'(i)) host_rdata = rbyte[i];
    end
  end
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_addr,
  input logic [7:0]        host_rdata,
  input logic [2*NCH-1:0]  tc_acc,
  input logic [3*NCH-1:0]  tc_mode,
  input logic [NCH-1:0]    tc_bcd,
  input logic [NCH-1:0]    tc_load
);
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_load)); // R4

  AST_LOAD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_load) |-> $past(host_wr && (host_addr != 2'd3))); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && (host_addr == 2'd3)) |=>
      ($stable(tc_acc) && $stable(tc_mode) && $stable(tc_bcd))); // R2

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr == 2'd3)) |-> (host_rdata == 8'hFF)); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_acc
    AST_ACC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tc_acc[2*i +: 2] != 2'd0); // R2
  end
endmodule

bind tmr_host_regs tmr_host_regs_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .tc_acc     (tc_acc),
  .tc_mode    (tc_mode),
  .tc_bcd     (tc_bcd),
  .tc_load    (tc_load)
);

// File: tb/sim_tmr_host_regs.sv
`timescale 1ns/1ps
module sim_tmr_host_regs;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [5:0]  tc_acc;
  logic [8:0]  tc_mode;
  logic [2:0]  tc_bcd;
  logic [2:0]  tc_load;
  logic [47:0] tc_load_val;
  logic [15:0] cnt [3];
  logic [2:0]  outp = 3'b000;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tmr_host_regs #(.NCH(NCH)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .tc_acc      (tc_acc),
    .tc_mode     (tc_mode),
    .tc_bcd      (tc_bcd),
    .tc_load     (tc_load),
    .tc_load_val (tc_load_val),
    .tc_count    ({cnt[2], cnt[1], cnt[0]}),
    .tc_out      (outp)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] v;
    logic [15:0] ld_l, l1, l2, l3;
    logic [7:0] st;
    cnt[0] = 16'hBEEF; cnt[1] = 16'h0000; cnt[2] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 acc", {26'd0, tc_acc}, 32'h3F);
    chk("R1 mode", {23'd0, tc_mode}, {23'd0, 9'b011_011_011});
    chk("R1 bcd", {29'd0, tc_bcd}, 32'd0);
    chk("R1 load", {29'd0, tc_load}, 32'd0);
    rd_chk("R1 first live lo", 2'd0, 8'hEF);
    rd_chk("R1 live hi", 2'd0, 8'hBE);

    // R2 pointer reset on programming
    wr(2'd3, 8'b01_11_0100);
    wr(2'd1, 8'h11);
    wr(2'd3, 8'b01_11_0100);
    wr(2'd1, 8'h22);
    chk("R2 no load after reprogram lo", {29'd0, tc_load}, 32'd0);
    wr(2'd1, 8'h33);
    chk("R2 word reload", {16'd0, tc_load_val[31:16]}, 32'h3322);
    cnt[1] = 16'hA1B2;
    rd_chk("R2 read ptr lo", 2'd1, 8'hB2);
    wr(2'd3, 8'b01_11_0100);
    rd_chk("R2 read ptr reset", 2'd1, 8'hB2);

    for (int ch = 0; ch < 3; ch++) begin
      for (int acc = 1; acc <= 3; acc++) begin
        logic [2:0] md;
        logic       bc;
        logic [1:0] a2;
        logic [1:0] c2;
        logic [15:0] val;
        md = 3'((ch + acc) % 6);
        bc = acc[0];
        a2 = 2'(acc);
        c2 = 2'(ch);
        wr(2'd3, {c2, a2, md, bc});
        chk("R2 acc", {30'd0, tc_acc[2*ch +: 2]}, {30'd0, a2});
        chk("R2 mode", {29'd0, tc_mode[3*ch +: 3]}, {29'd0, md});
        chk("R2 bcd", {31'd0, tc_bcd[ch]}, {31'd0, bc});

        val = 16'h1234 + 16'(ch) * 16'h1111 + 16'(acc) * 16'h0F0F;
        if (acc == 1) begin
          wr(c2, val[7:0]);
          ld_l = {8'h00, val[7:0]};
        end else if (acc == 2) begin
          wr(c2, val[15:8]);
          ld_l = {val[15:8], 8'h00};
        end else begin
          wr(c2, val[7:0]);
          chk("R3 word first byte no load", {29'd0, tc_load}, 32'd0);
          wr(c2, val[15:8]);
          ld_l = val;
        end
        chk("R4 strobe", {29'd0, tc_load}, 32'(1 << ch));
        chk("R3 load value", {16'd0, tc_load_val[16*ch +: 16]}, {16'd0, ld_l});
        @(negedge clk);
        chk("R4 strobe one cycle", {29'd0, tc_load}, 32'd0);

        // R8 live reads
        l1 = val ^ 16'h5A5A;
        cnt[ch] = l1;
        if (acc == 1) begin
          rd_chk("R8 lo", c2, l1[7:0]);
          rd_chk("R8 lo again", c2, l1[7:0]);
        end else if (acc == 2) begin
          rd_chk("R8 hi", c2, l1[15:8]);
          rd_chk("R8 hi again", c2, l1[15:8]);
        end else begin
          rd_chk("R8 word lo", c2, l1[7:0]);
          rd_chk("R8 word hi", c2, l1[15:8]);
          rd_chk("R8 word lo2", c2, l1[7:0]);
          rd_chk("R8 word hi2", c2, l1[15:8]);
        end

        // R5 count latch, second request ignored
        wr(2'd3, {c2, 2'b00, 4'h0});
        l2 = l1 + 16'h0101;
        cnt[ch] = l2;
        wr(2'd3, {c2, 2'b00, 4'hF});
        chk("R5 latch leaves config", {30'd0, tc_acc[2*ch +: 2]}, {30'd0, a2});
        if (acc == 1) begin
          rd_chk("R5 latched lo", c2, l1[7:0]);
          rd_chk("R7 live after latch", c2, l2[7:0]);
        end else if (acc == 2) begin
          rd_chk("R5 latched hi", c2, l1[15:8]);
          rd_chk("R7 live after latch", c2, l2[15:8]);
        end else begin
          rd_chk("R5 latched word lo", c2, l1[7:0]);
          rd_chk("R7 latched word hi", c2, l1[15:8]);
          rd_chk("R7 live after latch lo", c2, l2[7:0]);
          rd_chk("R8 live hi", c2, l2[15:8]);
        end

        // R6 read-back: count and status
        outp[ch] = 1'b1;
        wr(2'd3, 8'hC0 | 8'(1 << (ch + 1)));
        st = {1'b1, 1'b0, a2, md, bc};
        outp[ch] = 1'b0;
        l3 = l2 + 16'h0001;
        cnt[ch] = l3;
        wr(2'd3, 8'hE0 | 8'(1 << (ch + 1)));
        rd_chk("R6 status byte", c2, st);
        if (acc == 1) begin
          rd_chk("R7 latched after status", c2, l2[7:0]);
        end else if (acc == 2) begin
          rd_chk("R7 latched after status", c2, l2[15:8]);
        end else begin
          rd_chk("R7 latched lo after status", c2, l2[7:0]);
          rd_chk("R7 latched hi after status", c2, l2[15:8]);
        end
        wr(2'd3, 8'hE0 | 8'(1 << (ch + 1)));
        rd_chk("R6 new status", c2, {1'b0, 1'b0, a2, md, bc});

        // R9 control read
        rd_chk("R9 ctrl read", 2'd3, 8'hFF);
        if (acc == 1) begin
          rd_chk("R9 live unaffected", c2, l3[7:0]);
        end else if (acc == 2) begin
          rd_chk("R9 live unaffected", c2, l3[15:8]);
        end else begin
          rd_chk("R9 live unaffected lo", c2, l3[7:0]);
          rd_chk("R8 live hi", c2, l3[15:8]);
        end
      end
    end

    // R6 multi-channel read-back, count only
    cnt[0] = 16'h1357; cnt[1] = 16'h2468; cnt[2] = 16'h9ABC;
    wr(2'd3, 8'b11_0_1_111_0);
    cnt[0] = 16'h0000; cnt[1] = 16'h0000; cnt[2] = 16'h0000;
    rd_chk("R6 multi ch0 lo", 2'd0, 8'h57);
    rd_chk("R6 multi ch0 hi", 2'd0, 8'h13);
    rd_chk("R6 multi ch1 lo", 2'd1, 8'h68);
    rd_chk("R6 multi ch1 hi", 2'd1, 8'h24);
    rd_chk("R6 multi ch2 lo", 2'd2, 8'hBC);
    rd_chk("R6 multi ch2 hi", 2'd2, 8'h9A);
    rd_chk("R6 no status latched", 2'd0, 8'h00);

    report();
  end
endmodule